// File: doc/BRIEF.md
# Bus clock-enable prescaler tree

This block runs entirely from one fast system clock and turns it into a family of single-cycle clock-enable strobes. Logic in a slower domain keeps running on the system clock and advances only on cycles where its strobe is high. The tree has a main bus domain, two peripheral bus domains (A and B) below it, one timer domain for each peripheral bus, an ADC domain below peripheral bus B, and a system-tick reference at one eighth of the main bus rate. A select input then chooses whether the tick strobe follows the main bus or that reference.

Each ratio comes from a small encoded select input. A new select value is applied only when the divider reaches the end of its current period, so a period is never cut short. Each timer domain runs at its bus rate when that bus divides by 1, and at twice the bus rate otherwise. A status output for each timer shows which of these two cases is in force.

Top module: `clk_en_tree`

## Requirements
- R1: `rst` is synchronous and active high. In the first cycle after it is released, with all selects at 0, `ce_main`, `ce_pa`, `ce_pb`, `ce_tim_a`, `ce_tim_b` and `ce_tick` are 1, and `ce_adc`, `ce_tick_ref`, `tim_a_fast` and `tim_b_fast` are 0. All dividers then divide by 1, except the ADC divider (2) and the tick reference (8).
- R2: `sel_main` codes 0 to 7 give divide-by-1. Codes 8 to 15 give 2, 4, 8, 16, 64, 128, 256 and 512. `ce_main` is high in exactly one of every N system cycles. With N = 1 it is high in every cycle.
- R3: `sel_pa` and `sel_pb` codes 0 to 3 give divide-by-1, and codes 4 to 7 give 2, 4, 8 and 16. Each peripheral strobe is high only in cycles where `ce_main` is high, and on exactly one of every P main strobes.
- R4: When its bus divides by 1, a timer strobe has the bus rate and its fast flag is 0. When the bus divides by P > 1, the timer strobe fires on one of every P/2 main strobes and its fast flag is 1. A timer strobe is only high when `ce_main` is high.
- R5: `sel_adc` codes 0 to 5 give 2, 4, 6, 8, 12 and 16, and codes 6 and 7 give 16. `ce_adc` is high only when `ce_pb` is high, and on one of every D peripheral-B strobes.
- R6: `ce_tick_ref` is high on one of every 8 main strobes. `ce_tick` equals `ce_main` when `tick_use_ref` = 0 and equals `ce_tick_ref` when it is 1.
- R7: A select change takes effect only at the next period boundary of that divider. A strobe period already under way keeps its old length.
- R8: Every strobe lasts a single system cycle. A divider whose ratio is above 1 never asserts its strobe in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_main | input | 4 | Main bus ratio code |
| sel_pa | input | 3 | Peripheral bus A ratio code |
| sel_pb | input | 3 | Peripheral bus B ratio code |
| sel_adc | input | 3 | ADC ratio code (below bus B) |
| tick_use_ref | input | 1 | 1: tick follows the divide-by-8 reference; 0: tick follows the main bus |
| ce_main | output | 1 | Main bus enable strobe |
| ce_pa | output | 1 | Peripheral bus A enable strobe |
| ce_pb | output | 1 | Peripheral bus B enable strobe |
| ce_tim_a | output | 1 | Timer enable strobe for bus A |
| ce_tim_b | output | 1 | Timer enable strobe for bus B |
| ce_adc | output | 1 | ADC enable strobe |
| ce_tick_ref | output | 1 | Main bus divided by 8 |
| ce_tick | output | 1 | Selected tick strobe |
| tim_a_fast | output | 1 | Timer A runs at twice the bus A rate |
| tim_b_fast | output | 1 | Timer B runs at twice the bus B rate |

## Verification
Two events can land in the same cycle: a select change and the period boundary at which the divider loads the select. When that happens, the old ratio must still govern the period that has just ended. The bench provokes this by rewriting a select right after it sees a strobe. It also sweeps configurations while boundaries of nested dividers coincide, for example a main strobe that closes a bus period and an ADC period at once. A behavioural model built from integer counters judges every output in every cycle. Windowed strobe counts and an explicit gap measurement across a ratio change complete the check.

// File: rtl/clk_en_pkg.sv
package clk_en_pkg;

   // Main bus code: 0..7 -> 1, 8..11 -> 2..16, 12..15 -> 64..512 (32 skipped)
   function automatic int unsigned main_ratio(input int unsigned code);
      if (code < 8)
         return 1;
      else if (code < 12)
         return 32'd1 << (code - 7);
      else
         return 32'd1 << (code - 6);
   endfunction

   // Peripheral bus code: 0..3 -> 1, 4..7 -> 2,4,8,16
   function automatic int unsigned bus_ratio(input int unsigned code);
      if (code < 4)
         return 1;
      else
         return 32'd1 << (code - 3);
   endfunction

   // ADC code: six ratios, unused codes fall to 16
   function automatic int unsigned adc_ratio(input int unsigned code);
      case (code)
         0:       return 2;
         1:       return 4;
         2:       return 6;
         3:       return 8;
         4:       return 12;
         default: return 16;
      endcase
   endfunction

endpackage

// File: rtl/ce_div.sv
module ce_div #(
   parameter int RW        = 4,
   parameter int RST_RATIO = 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          parent_en,
   input  logic [RW-1:0] ratio_nxt,
   output logic          strobe
);

   logic [RW-1:0] cnt_q;
   logic [RW-1:0] cur_q;
   logic          wrap;

   assign wrap   = (cnt_q == cur_q - RW'(1));
   assign strobe = parent_en & wrap;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         cur_q <= RW'(RST_RATIO);
      end else if (parent_en) begin
         if (wrap) begin
            cnt_q <= '0;
            cur_q <= ratio_nxt;
         end else begin
            cnt_q <= cnt_q + RW'(1);
         end
      end
   end

endmodule

// File: rtl/pb_dom.sv
module pb_dom #(
   parameter int RW = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          main_en,
   input  logic [RW-1:0] ratio_nxt,
   output logic          bus_en,
   output logic          tim_en,
   output logic          tim_fast
);

   logic [RW-1:0] cnt_q;
   logic [RW-1:0] cur_q;
   logic          wrap;
   logic [RW-1:0] tim_ratio;

   assign wrap   = (cnt_q == cur_q - RW'(1));
   assign bus_en = main_en & wrap;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         cur_q <= RW'(1);
      end else if (main_en) begin
         if (wrap) begin
            cnt_q <= '0;
            cur_q <= ratio_nxt;
         end else begin
            cnt_q <= cnt_q + RW'(1);
         end
      end
   end

   // timer follows the applied bus ratio, halved unless it is 1
   assign tim_fast  = (cur_q != RW'(1));
   assign tim_ratio = tim_fast ? (cur_q >> 1) : RW'(1);

   ce_div #(.RW(RW), .RST_RATIO(1)) u_tim (
      .clk       (clk),
      .rst       (rst),
      .parent_en (main_en),
      .ratio_nxt (tim_ratio),
      .strobe    (tim_en)
   );

endmodule

// File: rtl/clk_en_tree.sv
module clk_en_tree
   import clk_en_pkg::*;
#(
   parameter int MAIN_SEL_W  = 4,
   parameter int BUS_SEL_W   = 3,
   parameter int ADC_SEL_W   = 3,
   parameter int MAIN_MAXDIV = 512,
   parameter int BUS_MAXDIV  = 16,
   parameter int ADC_MAXDIV  = 16,
   parameter int TICK_DIV    = 8
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [MAIN_SEL_W-1:0] sel_main,
   input  logic [BUS_SEL_W-1:0]  sel_pa,
   input  logic [BUS_SEL_W-1:0]  sel_pb,
   input  logic [ADC_SEL_W-1:0]  sel_adc,
   input  logic                  tick_use_ref,
   output logic                  ce_main,
   output logic                  ce_pa,
   output logic                  ce_pb,
   output logic                  ce_tim_a,
   output logic                  ce_tim_b,
   output logic                  ce_adc,
   output logic                  ce_tick_ref,
   output logic                  ce_tick,
   output logic                  tim_a_fast,
   output logic                  tim_b_fast
);

   localparam int MAIN_RW = $clog2(MAIN_MAXDIV + 1);
   localparam int BUS_RW  = $clog2(BUS_MAXDIV + 1);
   localparam int ADC_RW  = $clog2(ADC_MAXDIV + 1);
   localparam int TICK_RW = $clog2(TICK_DIV + 1);
   localparam int N_BUS   = 2;

   initial begin
      assert (MAIN_MAXDIV >= 512) else $error("MAIN_MAXDIV below largest code");
      assert (BUS_MAXDIV  >= 16)  else $error("BUS_MAXDIV below largest code");
      assert (ADC_MAXDIV  >= 16)  else $error("ADC_MAXDIV below largest code");
      assert (TICK_DIV    >= 1)   else $error("TICK_DIV must be positive");
   end

   logic [MAIN_RW-1:0]  main_nxt;
   logic [BUS_SEL_W-1:0] bus_sel [N_BUS];
   logic [N_BUS-1:0]    bus_en;
   logic [N_BUS-1:0]    tim_en;
   logic [N_BUS-1:0]    tim_fast;

   assign main_nxt = MAIN_RW'(main_ratio(32'(sel_main)));

   ce_div #(.RW(MAIN_RW), .RST_RATIO(1)) u_main (
      .clk       (clk),
      .rst       (rst),
      .parent_en (1'b1),
      .ratio_nxt (main_nxt),
      .strobe    (ce_main)
   );

   assign bus_sel[0] = sel_pa;
   assign bus_sel[1] = sel_pb;

   for (genvar g = 0; g < N_BUS; g++) begin : g_bus
      logic [BUS_RW-1:0] nxt;
      assign nxt = BUS_RW'(bus_ratio(32'(bus_sel[g])));
      pb_dom #(.RW(BUS_RW)) u_dom (
         .clk       (clk),
         .rst       (rst),
         .main_en   (ce_main),
         .ratio_nxt (nxt),
         .bus_en    (bus_en[g]),
         .tim_en    (tim_en[g]),
         .tim_fast  (tim_fast[g])
      );
   end

   assign ce_pa      = bus_en[0];
   assign ce_pb      = bus_en[1];
   assign ce_tim_a   = tim_en[0];
   assign ce_tim_b   = tim_en[1];
   assign tim_a_fast = tim_fast[0];
   assign tim_b_fast = tim_fast[1];

   logic [ADC_RW-1:0] adc_nxt;
   assign adc_nxt = ADC_RW'(adc_ratio(32'(sel_adc)));

   ce_div #(.RW(ADC_RW), .RST_RATIO(2)) u_adc (
      .clk       (clk),
      .rst       (rst),
      .parent_en (ce_pb),
      .ratio_nxt (adc_nxt),
      .strobe    (ce_adc)
   );

   if (TICK_DIV == 1) begin : g_tick_pass
      assign ce_tick_ref = ce_main;
   end else begin : g_tick_div
      ce_div #(.RW(TICK_RW), .RST_RATIO(TICK_DIV)) u_tick (
         .clk       (clk),
         .rst       (rst),
         .parent_en (ce_main),
         .ratio_nxt (TICK_RW'(TICK_DIV)),
         .strobe    (ce_tick_ref)
      );
   end

   assign ce_tick = tick_use_ref ? ce_tick_ref : ce_main;

endmodule

// File: rtl/clk_en_tree_chk.sv
module clk_en_tree_chk (
   input logic clk,
   input logic rst,
   input logic ce_main,
   input logic ce_pa,
   input logic ce_pb,
   input logic ce_tim_a,
   input logic ce_tim_b,
   input logic ce_adc,
   input logic ce_tick_ref
);

   // R3
   pa_within_main_chk: assert property (@(posedge clk) disable iff (rst)
      ce_pa |-> ce_main);

   // R3
   pb_within_main_chk: assert property (@(posedge clk) disable iff (rst)
      ce_pb |-> ce_main);

   // R4
   tim_a_within_main_chk: assert property (@(posedge clk) disable iff (rst)
      ce_tim_a |-> ce_main);

   // R4
   tim_b_within_main_chk: assert property (@(posedge clk) disable iff (rst)
      ce_tim_b |-> ce_main);

   // R5
   adc_within_pb_chk: assert property (@(posedge clk) disable iff (rst)
      ce_adc |-> ce_pb);

   // R6
   tickref_within_main_chk: assert property (@(posedge clk) disable iff (rst)
      ce_tick_ref |-> ce_main);

   // R8
   adc_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
      ce_adc |=> !ce_adc);

   // R8
   tickref_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
      ce_tick_ref |=> !ce_tick_ref);

endmodule

bind clk_en_tree clk_en_tree_chk u_chk (
   .clk         (clk),
   .rst         (rst),
   .ce_main     (ce_main),
   .ce_pa       (ce_pa),
   .ce_pb       (ce_pb),
   .ce_tim_a    (ce_tim_a),
   .ce_tim_b    (ce_tim_b),
   .ce_adc      (ce_adc),
   .ce_tick_ref (ce_tick_ref)
);

// File: tb/clk_en_tree_tb.sv
module clk_en_tree_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] sel_main = '0;
   logic [2:0] sel_pa = '0;
   logic [2:0] sel_pb = '0;
   logic [2:0] sel_adc = '0;
   logic       tick_use_ref = 1'b0;
   logic ce_main, ce_pa, ce_pb, ce_tim_a, ce_tim_b, ce_adc;
   logic ce_tick_ref, ce_tick, tim_a_fast, tim_b_fast;

   always #10 clk = ~clk;

   clk_en_tree u_dut (
      .clk(clk), .rst(rst), .sel_main(sel_main), .sel_pa(sel_pa),
      .sel_pb(sel_pb), .sel_adc(sel_adc), .tick_use_ref(tick_use_ref),
      .ce_main(ce_main), .ce_pa(ce_pa), .ce_pb(ce_pb),
      .ce_tim_a(ce_tim_a), .ce_tim_b(ce_tim_b), .ce_adc(ce_adc),
      .ce_tick_ref(ce_tick_ref), .ce_tick(ce_tick),
      .tim_a_fast(tim_a_fast), .tim_b_fast(tim_b_fast)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   // independent decoders
   function automatic int m_main(input int s);
      int r = 1;
      if (s >= 8) begin
         r = 2;
         for (int k = 8; k < s; k++) r = (k == 11) ? r * 4 : r * 2;
      end
      return r;
   endfunction
   function automatic int m_bus(input int s);
      return (s < 4) ? 1 : (2 ** (s - 3));
   endfunction
   function automatic int m_adc(input int s);
      int t[8] = '{2, 4, 6, 8, 12, 16, 16, 16};
      return t[s];
   endfunction

   // model state: 0 main,1 pa,2 pb,3 tim a,4 tim b,5 adc,6 tick ref
   int mc[7];
   int mr[7];
   int tot[8];
   bit cmp_on = 0;

   task automatic adv(inout int c, inout int r, input bit p, input int nx);
      if (p) begin
         if (c == r - 1) begin c = 0; r = nx; end
         else c = c + 1;
      end
   endtask

   always @(negedge clk) begin
      if (rst) begin
         foreach (mc[i]) mc[i] = 0;
         mr = '{1, 1, 1, 1, 1, 2, 8};
      end else begin
         bit e[7];
         bit [9:0] exp_v, got_v;
         int ta, tb;
         e[0] = (mc[0] == mr[0] - 1);
         e[1] = e[0] && (mc[1] == mr[1] - 1);
         e[2] = e[0] && (mc[2] == mr[2] - 1);
         e[3] = e[0] && (mc[3] == mr[3] - 1);
         e[4] = e[0] && (mc[4] == mr[4] - 1);
         e[5] = e[2] && (mc[5] == mr[5] - 1);
         e[6] = e[0] && (mc[6] == 7);
         exp_v = {e[0], e[1], e[2], e[3], e[4], e[5], e[6],
                  tick_use_ref ? e[6] : e[0], mr[1] != 1, mr[2] != 1};
         got_v = {ce_main, ce_pa, ce_pb, ce_tim_a, ce_tim_b, ce_adc,
                  ce_tick_ref, ce_tick, tim_a_fast, tim_b_fast};
         if (cmp_on) begin
            checks++;
            // R2 R3 R4 R5 R6 R7 R8 cycle compare
            if (got_v !== exp_v) begin
               errors++;
               $display("FAIL R2-R8 cycle model: actual %b expected %b at %0t",
                        got_v, exp_v, $time);
            end
         end
         ta = (mr[1] == 1) ? 1 : mr[1] / 2;
         tb = (mr[2] == 1) ? 1 : mr[2] / 2;
         adv(mc[0], mr[0], 1'b1, m_main(int'(sel_main)));
         adv(mc[1], mr[1], e[0], m_bus(int'(sel_pa)));
         adv(mc[2], mr[2], e[0], m_bus(int'(sel_pb)));
         adv(mc[3], mr[3], e[0], ta);
         adv(mc[4], mr[4], e[0], tb);
         adv(mc[5], mr[5], e[2], m_adc(int'(sel_adc)));
         adv(mc[6], mr[6], e[0], 8);
         tot[0] += ce_main;  tot[1] += ce_pa;  tot[2] += ce_pb;
         tot[3] += ce_tim_a; tot[4] += ce_tim_b; tot[5] += ce_adc;
         tot[6] += ce_tick_ref; tot[7] += ce_tick;
      end
   end

   task automatic chk(input string tag, input int act, input int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   int prev_a = 1, prev_m = 8;

   task automatic run_cfg(input int a, input int p1, input int p2,
                          input int d, input bit ts, input int w);
      int A, P1, P2, D, T1, T2, m, settle;
      int snap[8];
      A = m_main(a); P1 = m_bus(p1); P2 = m_bus(p2); D = m_adc(d);
      T1 = (P1 == 1) ? 1 : P1 / 2;
      T2 = (P2 == 1) ? 1 : P2 / 2;
      m = P1; if (P2 * D > m) m = P2 * D; if (8 > m) m = 8;
      settle = 2 * ((A > prev_a) ? A : prev_a) * ((m > prev_m) ? m : prev_m) + 4;
      prev_a = A; prev_m = m;
      @(posedge clk); #1;
      sel_main = 4'(a); sel_pa = 3'(p1); sel_pb = 3'(p2);
      sel_adc = 3'(d); tick_use_ref = ts;
      repeat (settle) @(posedge clk);
      #1;
      snap = tot;
      repeat (w) @(posedge clk);
      #1;
      chk("R2 main count",     tot[0] - snap[0], w / A);
      chk("R3 bus A count",    tot[1] - snap[1], w / (A * P1));
      chk("R3 bus B count",    tot[2] - snap[2], w / (A * P2));
      chk("R4 timer A count",  tot[3] - snap[3], w / (A * T1));
      chk("R4 timer B count",  tot[4] - snap[4], w / (A * T2));
      chk("R5 adc count",      tot[5] - snap[5], w / (A * P2 * D));
      chk("R6 tick ref count", tot[6] - snap[6], w / (A * 8));
      chk("R6 tick count",     tot[7] - snap[7], ts ? w / (A * 8) : w / A);
      chk("R4 timer A flag", int'(tim_a_fast), int'(P1 != 1));
      chk("R4 timer B flag", int'(tim_b_fast), int'(P2 != 1));
   endtask

   task automatic gap_main(output int n);
      n = 0;
      do begin @(negedge clk); n++; end while (!ce_main);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int g1, g2;
      repeat (4) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk("R1 ce_main", int'(ce_main), 1);
      chk("R1 ce_pa", int'(ce_pa), 1);
      chk("R1 ce_pb", int'(ce_pb), 1);
      chk("R1 timers", int'({ce_tim_a, ce_tim_b}), 3);
      chk("R1 ce_adc", int'(ce_adc), 0);
      chk("R1 ce_tick_ref", int'(ce_tick_ref), 0);
      chk("R1 ce_tick", int'(ce_tick), 1);
      chk("R1 fast flags", int'({tim_a_fast, tim_b_fast}), 0);
      cmp_on = 1;
      // R2 main sweep
      for (int a = 0; a < 16; a++) run_cfg(a, 0, 0, 0, a[0], 16 * m_main(a));
      // R3 R4 bus sweep, ADC varying too
      for (int p = 0; p < 8; p++) run_cfg(0, p, 7 - p, p, p[0], 768);
      // R5 ADC sweep
      for (int d = 0; d < 8; d++) run_cfg(0, 6, 5, d, 1'b1, 768);
      for (int d = 0; d < 8; d++) run_cfg(0, 0, 0, d, 1'b0, 768);
      // R7 change right after a boundary: old period finishes first
      run_cfg(10, 0, 0, 0, 1'b0, 64);
      gap_main(g1);
      @(posedge clk); #1 sel_main = 4'd8;
      gap_main(g1);
      gap_main(g2);
      chk("R7 gap before change", g1, 8);
      chk("R7 gap after change", g2, 2);
      // R8 divide by 2 bus never two in a row
      run_cfg(0, 4, 4, 0, 1'b0, 768);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule